// File: doc/BRIEF.md
# Transmit DMA Channel over a Descriptor Ring

This block is one transmit DMA channel. Software places 8-byte descriptors in a ring in memory. Each descriptor has a control word and a buffer address. Software then advances a posted-end pointer. The channel walks the ring from the base. It fetches each descriptor through a simple read port with a fixed one-cycle latency, then reads the buffer one byte at a time. Each byte goes out on a byte stream that marks the frame start and the frame end.

Four software registers control the channel: control, ring base, posted-end pointer and status. The status register shows a 4-bit channel state, an error code and the current descriptor offset. A descriptor can ask for an interrupt pulse when it finishes. It can also mark the end of the table, which sends the walk back to the ring base. Software can request a suspend, which halts the channel only between frames.

Top module: `txring_dma`

## Requirements
- R1: After synchronous reset every register reads zero, the status reads state 0 (disabled) with offset 0, and no memory request or stream byte is issued.
- R2: Register map, selected by `cfg_addr`. At 0 is control: bit 0 enable, bit 1 suspend request, bits 20:18 burst-size code N (meaning 2^(N+4) bytes, stored and read back only). At 1 is the ring base, which keeps bits 31:12 and reads zero below. At 2 is the posted-end offset, which keeps bits 11:3 and reads zero elsewhere. At 3 is status: offset in 11:0, state in 15:12, error in 19:16.
- R3: The descriptor at offset O is read as two words. The control word is at base+O and the buffer address is at base+O+4. In the control word, bits 12:0 hold the byte count, bit 28 ends the table, bit 29 requests an interrupt, bit 30 ends a frame and bit 31 starts a frame.
- R4: A descriptor's bytes come out in ascending address order, one per `tx_valid` cycle. The byte at address A is taken from lane A[1:0] (bits 8*A[1:0]+7 down to 8*A[1:0]) of the word read from A with bits 1:0 cleared. `tx_sof` marks the first byte of a start-of-frame descriptor, and `tx_eof` marks the last byte of an end-of-frame descriptor.
- R5: While the channel is enabled, it processes descriptors while the current offset differs from the posted-end offset. When the two are equal it reads state 2 (idle-wait), and it resumes when a new posted-end value is written.
- R6: After a descriptor completes, the offset becomes 0 if that descriptor had end-of-table set. Otherwise it grows by 8, modulo 4096.
- R7: `irq` is high for exactly the cycle that carries the last byte of a descriptor with the interrupt bit set, and at no other time.
- R8: A zero byte count, or a descriptor without start-of-frame that follows a finished frame, gives error 1. No byte of that descriptor is sent.
- R9: An error response on either descriptor word gives error 4, and no byte of that descriptor is sent.
- R10: An error response on a buffer read gives error 3. The bytes before it are sent, and the failing byte is not. Any error sets state 3, stops all activity and holds until enable is cleared.
- R11: A suspend request halts the channel only when no frame is open. Until then the state reads 4, and after the halt it reads 3 with error 0. Clearing the request resumes at the same descriptor.
- R12: Clearing enable gives state 0, offset 0 and error 0, with no stream byte on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| mem_err | input | 1 | Error response, one cycle after the request |
| tx_valid | output | 1 | Stream byte valid |
| tx_byte | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| irq | output | 1 | Completion interrupt pulse |

## Verification
The bench targets several corner cases:
- A buffer that starts mid-word and crosses a word boundary. A wrong lane pick would send shuffled bytes.
- An end-of-table descriptor, after which the offset must drop to 0 rather than step on.
- A suspend raised inside an open frame. A wrong design would halt between the two descriptors of that frame, or would run on into the next frame.
- A bus error in the middle of a buffer. The bench checks that exactly the earlier bytes leave, with no frame-end marker.
- Protocol and descriptor-read errors, which must leave the stream silent.

// File: rtl/txring_pkg.sv
package txring_pkg;

    localparam int WORD_W    = 32;
    localparam int PAGE_BITS = 12;
    localparam int CNT_W     = 13;
    localparam int SLOT_BITS = 3;
    localparam int POST_W    = PAGE_BITS - SLOT_BITS;
    localparam int HI_W      = WORD_W - PAGE_BITS;
    localparam int LANES     = WORD_W / 8;

    typedef enum logic [3:0] {
        CH_OFF   = 4'd0,
        CH_RUN   = 4'd1,
        CH_IDLE  = 4'd2,
        CH_HALT  = 4'd3,
        CH_SUSPP = 4'd4
    } chan_state_e;

    typedef enum logic [3:0] {
        E_NONE     = 4'd0,
        E_PROTO    = 4'd1,
        E_UNDERRUN = 4'd2,
        E_BUFBUS   = 4'd3,
        E_DESCBUS  = 4'd4
    } chan_err_e;

    typedef enum logic [2:0] {
        F_OFF, F_CHK, F_D0, F_D1, F_D2, F_B0, F_B1, F_HALT
    } walk_e;

    typedef struct packed {
        logic             sof;
        logic             eof;
        logic             ioc;
        logic             eot;
        logic [CNT_W-1:0] cnt;
    } dctl_t;

    typedef struct packed {
        logic              en;
        logic              susp;
        logic [2:0]        burst;
        logic [HI_W-1:0]   base_hi;
        logic [POST_W-1:0] post;
    } cfg_t;

    function automatic dctl_t decode_ctl(input logic [WORD_W-1:0] w);
        dctl_t d;
        d.sof = w[31];
        d.eof = w[30];
        d.ioc = w[29];
        d.eot = w[28];
        d.cnt = w[CNT_W-1:0];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input chan_state_e s,
                                                      input chan_err_e e,
                                                      input logic [PAGE_BITS-1:0] cur);
        return {12'b0, e, s, cur};
    endfunction

endpackage

// File: rtl/txring_regs.sv
module txring_regs
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] status_word,
    output logic [WORD_W-1:0] rdata,
    output cfg_t              cfg
);
    cfg_t cfg_q;
    logic unused_wbit;

    assign unused_wbit = wdata[2];
    assign cfg = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            case (addr)
                2'd0: begin
                    cfg_q.en    <= wdata[0];
                    cfg_q.susp  <= wdata[1];
                    cfg_q.burst <= wdata[20:18];
                end
                2'd1: cfg_q.base_hi <= wdata[WORD_W-1:PAGE_BITS];
                2'd2: cfg_q.post    <= wdata[PAGE_BITS-1:SLOT_BITS];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            2'd0:    rdata = {11'b0, cfg_q.burst, 16'b0, cfg_q.susp, cfg_q.en};
            2'd1:    rdata = {cfg_q.base_hi, {PAGE_BITS{1'b0}}};
            2'd2:    rdata = {{HI_W{1'b0}}, cfg_q.post, {SLOT_BITS{1'b0}}};
            default: rdata = status_word;
        endcase
    end

endmodule

// File: rtl/txring_lane.sv
module txring_lane #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] word,
    input  logic [SEL_W-1:0]        sel,
    output logic [LANE_W-1:0]       lane
);
    logic [LANE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*LANE_W +: LANE_W];
    end

    assign lane = lanes[sel];

endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_sof,
    output logic              tx_eof,
    output logic              irq,
    output logic [WORD_W-1:0] status_word
);
    walk_e                st_q;
    chan_err_e            err_q;
    chan_state_e          ch_state;
    logic [PAGE_BITS-1:0] cur_q;
    logic [PAGE_BITS-1:0] post_off;
    logic                 in_frame_q;
    dctl_t                dctl_q;
    logic [WORD_W-1:0]    buf_q;
    logic [CNT_W-1:0]     idx_q;
    logic [WORD_W-1:0]    byte_addr;
    logic [7:0]           lane_byte;
    logic                 last_byte;
    logic                 valid_q, sof_q, eof_q, irq_q;
    logic [7:0]           byte_q;
    logic [2:0]           unused_burst;

    assign unused_burst = cfg.burst;
    assign post_off     = {cfg.post, {SLOT_BITS{1'b0}}};
    assign byte_addr    = buf_q + WORD_W'(idx_q);
    assign last_byte    = (idx_q == dctl_q.cnt - CNT_W'(1));

    txring_lane #(.LANES(LANES), .LANE_W(8)) u_lane (
        .word (mem_rdata),
        .sel  (byte_addr[$clog2(LANES)-1:0]),
        .lane (lane_byte)
    );

    always_comb begin
        mem_req  = 1'b0;
        mem_addr = '0;
        case (st_q)
            F_D0: begin
                mem_req  = 1'b1;
                mem_addr = {cfg.base_hi, cur_q};
            end
            F_D1: begin
                mem_req  = 1'b1;
                mem_addr = {cfg.base_hi, cur_q | PAGE_BITS'(4)};
            end
            F_B0: begin
                mem_req  = 1'b1;
                mem_addr = {byte_addr[WORD_W-1:2], 2'b00};
            end
            default: ;
        endcase
    end

    always_comb begin
        case (st_q)
            F_OFF:  ch_state = CH_OFF;
            F_HALT: ch_state = CH_HALT;
            F_CHK: begin
                if (cfg.susp)             ch_state = in_frame_q ? CH_SUSPP : CH_HALT;
                else if (cur_q == post_off) ch_state = CH_IDLE;
                else                      ch_state = CH_RUN;
            end
            default: ch_state = cfg.susp ? CH_SUSPP : CH_RUN;
        endcase
    end

    assign status_word = pack_status(ch_state, err_q, cur_q);

    always_ff @(posedge clk) begin
        valid_q <= 1'b0;
        sof_q   <= 1'b0;
        eof_q   <= 1'b0;
        irq_q   <= 1'b0;
        if (rst) begin
            st_q       <= F_OFF;
            err_q      <= E_NONE;
            cur_q      <= '0;
            in_frame_q <= 1'b0;
            dctl_q     <= '0;
            buf_q      <= '0;
            idx_q      <= '0;
            byte_q     <= '0;
        end else if (!cfg.en) begin
            st_q       <= F_OFF;
            err_q      <= E_NONE;
            cur_q      <= '0;
            in_frame_q <= 1'b0;
        end else begin
            case (st_q)
                F_OFF: st_q <= F_CHK;
                F_CHK: begin
                    if (!(cfg.susp && !in_frame_q) && cur_q != post_off)
                        st_q <= F_D0;
                end
                F_D0: st_q <= F_D1;
                F_D1: begin
                    if (mem_err) begin
                        err_q <= E_DESCBUS;
                        st_q  <= F_HALT;
                    end else begin
                        dctl_q <= decode_ctl(mem_rdata);
                        st_q   <= F_D2;
                    end
                end
                F_D2: begin
                    if (mem_err) begin
                        err_q <= E_DESCBUS;
                        st_q  <= F_HALT;
                    end else if (dctl_q.cnt == '0 || (!in_frame_q && !dctl_q.sof)) begin
                        err_q <= E_PROTO;
                        st_q  <= F_HALT;
                    end else begin
                        buf_q <= mem_rdata;
                        idx_q <= '0;
                        st_q  <= F_B0;
                    end
                end
                F_B0: st_q <= F_B1;
                F_B1: begin
                    if (mem_err) begin
                        err_q <= E_BUFBUS;
                        st_q  <= F_HALT;
                    end else begin
                        valid_q <= 1'b1;
                        byte_q  <= lane_byte;
                        sof_q   <= dctl_q.sof && (idx_q == '0);
                        eof_q   <= dctl_q.eof && last_byte;
                        if (last_byte) begin
                            irq_q      <= dctl_q.ioc;
                            in_frame_q <= !dctl_q.eof;
                            cur_q      <= dctl_q.eot ? '0 : cur_q + PAGE_BITS'(8);
                            st_q       <= F_CHK;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                            st_q  <= F_B0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign tx_valid = valid_q;
    assign tx_byte  = byte_q;
    assign tx_sof   = sof_q;
    assign tx_eof   = eof_q;
    assign irq      = irq_q;

    // R7
    irq_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> valid_q);

    // R4
    sof_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
        sof_q |-> valid_q);

    // R4
    eof_with_byte_chk: assert property (@(posedge clk) disable iff (rst)
        eof_q |-> valid_q);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q != E_NONE && cfg.en) |=> (err_q == $past(err_q)));

    // R12
    off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> (!valid_q && !irq_q));

endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txring_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_sof,
    output logic        tx_eof,
    output logic        irq
);
    cfg_t              cfg;
    logic [WORD_W-1:0] status_word;

    txring_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .status_word (status_word),
        .rdata       (cfg_rdata),
        .cfg         (cfg)
    );

    txring_walker u_walk (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .mem_err     (mem_err),
        .tx_valid    (tx_valid),
        .tx_byte     (tx_byte),
        .tx_sof      (tx_sof),
        .tx_eof      (tx_eof),
        .irq         (irq),
        .status_word (status_word)
    );

endmodule

// File: tb/txring_dma_tb_top.sv
`timescale 1ns/1ps
module txring_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        tx_valid, tx_sof, tx_eof, irq;
    logic [7:0]  tx_byte;

    logic [31:0] ring_w [0:1023];
    logic        bad_en = 1'b0;
    logic [31:0] bad_addr = '0;
    logic [10:0] exp_q [$];
    logic [10:0] exp_e;
    int n_chk = 0, n_bad = 0, s_cmp = 0, s_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    txring_dma dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_sof(tx_sof),
        .tx_eof(tx_eof), .irq(irq)
    );

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h3C;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        logic [31:0] w;
        if (a[31:12] == 20'h1) return ring_w[a[11:2]];
        for (int k = 0; k < 4; k++) w[8*k +: 8] = byte_at({a[31:2], 2'b00} + 32'(k));
        return w;
    endfunction

    function automatic logic [31:0] mk(input logic s, input logic e, input logic i,
                                       input logic t, input int cnt);
        return {s, e, i, t, 15'b0, 13'(cnt)};
    endfunction

    // memory model: response one cycle after request
    always @(posedge clk) begin
        mem_rdata <= word_at(mem_addr);
        mem_err   <= mem_req && bad_en && (mem_addr == bad_addr);
    end

    // stream comparison on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (tx_valid) begin
                s_cmp++;
                if (exp_q.size() == 0) begin
                    s_bad++;
                    $display("FAIL R4 R7 unexpected byte act=%h exp=none", tx_byte);
                end else begin
                    exp_e = exp_q.pop_front();
                    if ({irq, tx_eof, tx_sof, tx_byte} != exp_e) begin
                        s_bad++;
                        $display("FAIL R4 R7 stream act=%h exp=%h",
                                 {irq, tx_eof, tx_sof, tx_byte}, exp_e);
                    end
                end
            end else if (irq) begin
                s_cmp++; s_bad++;
                $display("FAIL R7 irq without byte act=1 exp=0");
            end
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic put_desc(input int slot, input logic [31:0] c, input logic [31:0] b);
        ring_w[slot*2]   = c;
        ring_w[slot*2+1] = b;
    endtask

    task automatic push_bytes(input logic [31:0] b, input int cnt, input logic s,
                              input logic e, input logic i, input int upto);
        for (int k = 0; k < upto; k++)
            exp_q.push_back({i && k == cnt-1, e && k == cnt-1, s && k == 0, byte_at(b + 32'(k))});
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + s_cmp, n_bad + s_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
    end

    initial begin
        logic [31:0] v;
        for (int k = 0; k < 1024; k++) ring_w[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(2'd3, v); check_eq("R1 status after reset", v, 32'h0);
        rd(2'd0, v); check_eq("R1 control after reset", v, 32'h0);
        check_eq("R1 no request after reset", {31'b0, mem_req}, 32'h0);

        // basic two-descriptor frame, unaligned buffer
        wr(2'd1, 32'h0000_1000);
        put_desc(0, mk(1, 0, 0, 0, 5), 32'h103);
        put_desc(1, mk(0, 1, 1, 0, 3), 32'h200);
        push_bytes(32'h103, 5, 1, 0, 0, 5);
        push_bytes(32'h200, 3, 0, 1, 1, 3);
        wr(2'd2, 32'd16);
        wr(2'd0, 32'h1);
        settle(80);
        check_eq("R3 R4 frame drained", 32'(exp_q.size()), 0);
        rd(2'd3, v); check_eq("R5 idle after posted end", v, 32'h0000_2010);

        // post one more single-byte frame
        put_desc(2, mk(1, 1, 0, 0, 1), 32'h7FF);
        push_bytes(32'h7FF, 1, 1, 1, 0, 1);
        wr(2'd2, 32'd24);
        settle(40);
        check_eq("R5 resumed frame drained", 32'(exp_q.size()), 0);
        rd(2'd3, v); check_eq("R6 offset stepped by 8", v, 32'h0000_2018);

        // end-of-table wrap
        put_desc(3, mk(1, 1, 1, 1, 2), 32'h0F0);
        push_bytes(32'h0F0, 2, 1, 1, 1, 2);
        wr(2'd2, 32'd0);
        settle(40);
        check_eq("R6 wrap frame drained", 32'(exp_q.size()), 0);
        rd(2'd3, v); check_eq("R6 wrapped to base", v, 32'h0000_2000);

        // missing start-of-frame after a finished frame
        put_desc(0, mk(0, 1, 0, 0, 4), 32'h400);
        wr(2'd2, 32'd8);
        settle(30);
        rd(2'd3, v); check_eq("R8 missing sof error", v, 32'h0001_3000);

        // disable clears, burst field readback
        wr(2'd0, 32'h0014_0000);
        settle(2);
        rd(2'd3, v); check_eq("R12 disable clears status", v, 32'h0);
        rd(2'd0, v); check_eq("R2 control readback", v, 32'h0014_0000);

        // zero byte count
        put_desc(0, mk(1, 1, 0, 0, 0), 32'h400);
        wr(2'd0, 32'h1);
        settle(30);
        rd(2'd3, v); check_eq("R8 zero count error", v, 32'h0001_3000);

        // bus error on descriptor read
        wr(2'd0, 32'h0);
        put_desc(0, mk(1, 1, 0, 0, 2), 32'h040);
        bad_en = 1'b1; bad_addr = 32'h1000;
        wr(2'd0, 32'h1);
        settle(30);
        rd(2'd3, v); check_eq("R9 descriptor bus error", v, 32'h0004_3000);
        settle(10);
        rd(2'd3, v); check_eq("R10 error held while enabled", v, 32'h0004_3000);

        // bus error mid-buffer
        wr(2'd0, 32'h0);
        bad_addr = 32'h304;
        put_desc(0, mk(1, 1, 1, 0, 6), 32'h300);
        push_bytes(32'h300, 6, 1, 1, 1, 4);
        wr(2'd0, 32'h1);
        settle(40);
        check_eq("R10 bytes before fault", 32'(exp_q.size()), 0);
        rd(2'd3, v); check_eq("R10 buffer bus error", v, 32'h0003_3000);

        // suspend
        wr(2'd0, 32'h0);
        bad_en = 1'b0;
        put_desc(0, mk(1, 0, 0, 0, 3), 32'h500);
        put_desc(1, mk(0, 1, 0, 0, 2), 32'h600);
        put_desc(2, mk(1, 1, 1, 0, 2), 32'h700);
        wr(2'd2, 32'd24);
        wr(2'd0, 32'h3);
        settle(10);
        rd(2'd3, v); check_eq("R11 suspended between frames", v, 32'h0000_3000);
        check_eq("R11 nothing sent while suspended", 32'(exp_q.size()), 0);
        push_bytes(32'h500, 3, 1, 0, 0, 3);
        push_bytes(32'h600, 2, 0, 1, 0, 2);
        wr(2'd0, 32'h1);
        settle(3);
        wr(2'd0, 32'h3);
        rd(2'd3, v); check_eq("R11 suspend pending in frame", v, 32'h0000_4000);
        settle(60);
        check_eq("R11 frame finished before halt", 32'(exp_q.size()), 0);
        rd(2'd3, v); check_eq("R11 halted at frame boundary", v, 32'h0000_3010);
        push_bytes(32'h700, 2, 1, 1, 1, 2);
        wr(2'd0, 32'h1);
        settle(40);
        check_eq("R11 resumed same descriptor", 32'(exp_q.size()), 0);
        rd(2'd3, v); check_eq("R11 idle after resume", v, 32'h0000_2018);

        // register masking
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h0000_0FFF);
        rd(2'd2, v); check_eq("R2 posted-end mask", v, 32'h0000_0FF8);
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, v); check_eq("R2 base mask", v, 32'h1234_5000);

        settle(5);
        summary();
    end

endmodule